// File: doc/BRIEF.md
# Message Interrupt Source Controller

This block holds the per-source state for a set of edge-style (message) interrupt sources and turns their trigger pulses into offers for a downstream presentation unit. Each source has an entry with a destination server, an 8-bit priority, a rejected flag and a masked-pending flag. Priority 0xFF means the source is masked. A trigger on a masked source is remembered rather than lost, and it is replayed once software gives the source a real priority. The presentation unit may turn an offer down. It does so by naming the source on the reject port, and the source then waits for a resend request. A resend walks the table one entry per cycle and re-offers every rejected, unmasked source.

Sources are addressed by a global number equal to the local index plus a fixed offset of 16. A configuration port writes or reads the server and priority of an entry and answers one cycle later with a status byte. Offers leave through a single registered valid/ready channel, one per cycle at most. When several sources are waiting, the lowest index goes first.

Top module: `isc_ctrl`

## Requirements
- R1: With the default parameters, local source i has the global number i+16. Only global numbers 16 to 31 address an entry, and every offer carries the global number of its source.
- R2: After reset every entry holds priority 0xFF and server 0. No offer is valid, `busy_o` is low and no configuration response is valid.
- R3: A trigger pulse on an unmasked source (priority not 0xFF) produces exactly one offer. The offer carries that source's global number, priority and server.
- R4: A trigger on a masked source produces no offer and sets the masked-pending flag. A later valid write with a priority other than 0xFF clears the flag and produces one offer using the newly written priority and server. A write that keeps priority 0xFF leaves the flag set and produces no offer.
- R5: A reject naming a valid global number marks that source as rejected and produces no offer by itself. A reject naming an out-of-range number changes no entry.
- R6: A resend request received while idle raises `busy_o` on the next cycle for exactly NUM_SRC cycles. During that time the scan visits the entries in ascending order. Each rejected entry has its flag cleared and is re-offered once if its priority is not 0xFF. A rejected entry that is masked is dropped, and a second resend does not offer it.
- R7: Triggers and rejects that arrive while `busy_o` is high produce no offer during the scan. They are applied as soon as the scan ends.
- R8: Offers use valid/ready. While `offer_valid_o` is high and `offer_ready_i` is low, the offer's fields stay unchanged. When several sources wait at once, they are offered in ascending index order.
- R9: A configuration write is refused with status 0xFD (-3 as a signed byte) if any of these holds: the number is out of range, the server is at or above NUM_SRV, or the 9-bit priority exceeds 0xFF. A refused write leaves the entry unchanged. An accepted write returns status 0x00. The response comes one cycle after the request.
- R10: A configuration read of a valid number returns status 0x00 with the entry's server and priority. A read of an out-of-range number returns status 0xFD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | NUM_SRC | One-cycle trigger pulse per source |
| rej_valid_i | input | 1 | Reject from the presentation unit |
| rej_num_i | input | GNUM_W | Global number being rejected |
| resend_i | input | 1 | Request to re-offer rejected sources |
| busy_o | output | 1 | Resend scan in progress |
| offer_valid_o | output | 1 | Offer available |
| offer_ready_i | input | 1 | Presentation unit takes the offer |
| offer_num_o | output | GNUM_W | Global number of the offered source |
| offer_prio_o | output | 8 | Priority of the offer |
| offer_server_o | output | SRV_W | Destination server of the offer |
| cfg_valid_i | input | 1 | Configuration request |
| cfg_write_i | input | 1 | 1 = write, 0 = read |
| cfg_num_i | input | GNUM_W | Global number addressed |
| cfg_server_i | input | SRVIN_W | Server to write |
| cfg_prio_i | input | 9 | Priority to write (values above 0xFF are refused) |
| cfg_rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| cfg_status_o | output | 8 | 0x00 success, 0xFD error |
| cfg_server_o | output | SRV_W | Server of the entry (read) or the value written |
| cfg_prio_o | output | 8 | Priority of the entry (read) or the value written |

## Verification
The hardest situation to reach is an event that arrives during a resend scan. The bench issues a resend and, while `busy_o` is high, fires a trigger and a reject. It confirms that no offer appears before `busy_o` falls, that the held trigger is offered right after, and that the held reject is only re-offered on the following resend. A second hard case is the masked-pending replay. A trigger is made on a masked source, and then two writes follow: one that keeps it masked and one that unmasks it. Exactly one offer must appear, and it must carry the written values. A reject with an out-of-range number whose low bits alias an unmasked entry shows any missing range check on the next resend.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam logic [7:0] PRIO_MASKED = 8'hFF;
  localparam logic [7:0] ST_OK       = 8'h00;
  localparam logic [7:0] ST_ERR      = 8'hFD;  // -3 as a signed byte
endpackage

// File: rtl/isc_entry.sv
module isc_entry
  import isc_pkg::*;
#(
  parameter int SRV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  input  logic             flush_i,
  input  logic             trig_i,
  input  logic             rej_i,
  input  logic             scan_hit_i,
  input  logic             wr_i,
  input  logic [SRV_W-1:0] wr_server_i,
  input  logic [7:0]       wr_prio_i,
  input  logic             take_i,
  output logic [SRV_W-1:0] server_o,
  output logic [7:0]       prio_o,
  output logic             want_o
);
  logic rejected, mpend, hold_trig, hold_rej;
  logic fire, mark_rej, unmask, rescan, set_want, masked;

  always_comb begin
    masked   = (prio_o == PRIO_MASKED);
    fire     = (trig_i & ~busy_i) | (flush_i & hold_trig);
    mark_rej = (rej_i & ~busy_i) | (flush_i & hold_rej);
    unmask   = wr_i & mpend & (wr_prio_i != PRIO_MASKED);
    rescan   = scan_hit_i & rejected;
    set_want = unmask | ((fire | rescan) & ~masked);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      server_o  <= '0;
      prio_o    <= PRIO_MASKED;
      want_o    <= 1'b0;
      rejected  <= 1'b0;
      mpend     <= 1'b0;
      hold_trig <= 1'b0;
      hold_rej  <= 1'b0;
    end else begin
      if (wr_i) begin
        server_o <= wr_server_i;
        prio_o   <= wr_prio_i;
      end
      want_o <= (want_o & ~take_i) | set_want;
      if (rescan)        rejected <= 1'b0;
      else if (mark_rej) rejected <= 1'b1;
      if (unmask)                 mpend <= 1'b0;
      else if (fire && masked)    mpend <= 1'b1;
      hold_trig <= busy_i ? (hold_trig | trig_i) : (hold_trig & ~flush_i);
      hold_rej  <= busy_i ? (hold_rej | rej_i)   : (hold_rej & ~flush_i);
    end
  end

  AST_MASKED_TRIG_KEPT: assert property (@(posedge clk) disable iff (rst)
    (trig_i && !busy_i && masked && !wr_i) |=> mpend);  // R4
  AST_HELD_NO_WANT: assert property (@(posedge clk) disable iff (rst)
    (busy_i && trig_i && !want_o && !rescan && !unmask) |=> !want_o);  // R7
endmodule

// File: rtl/isc_scan.sv
module isc_scan #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      idx_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (busy_o) begin
        if (idx_o == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          idx_o  <= '0;
        end else begin
          idx_o <= idx_o + 1'b1;
        end
      end else if (start_i) begin
        busy_o <= 1'b1;
        idx_o  <= '0;
      end
    end
  end

  AST_SCAN_STARTS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && idx_o == '0));  // R6
  AST_SCAN_ENDS: assert property (@(posedge clk) disable iff (rst)
    (busy_o && idx_o == LAST) |=> (!busy_o && done_o));  // R6
endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/isc_ctrl.sv
module isc_ctrl
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int OFFSET  = 16,
  parameter int NUM_SRV = 4,
  parameter int GNUM_W  = 8,
  parameter int SRVIN_W = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int SRV_W  = $clog2(NUM_SRV)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic               rej_valid_i,
  input  logic [GNUM_W-1:0]  rej_num_i,
  input  logic               resend_i,
  output logic               busy_o,
  output logic               offer_valid_o,
  input  logic               offer_ready_i,
  output logic [GNUM_W-1:0]  offer_num_o,
  output logic [7:0]         offer_prio_o,
  output logic [SRV_W-1:0]   offer_server_o,
  input  logic               cfg_valid_i,
  input  logic               cfg_write_i,
  input  logic [GNUM_W-1:0]  cfg_num_i,
  input  logic [SRVIN_W-1:0] cfg_server_i,
  input  logic [8:0]         cfg_prio_i,
  output logic               cfg_rsp_valid_o,
  output logic [7:0]         cfg_status_o,
  output logic [SRV_W-1:0]   cfg_server_o,
  output logic [7:0]         cfg_prio_o
);
  localparam logic [GNUM_W-1:0]  G_LO    = GNUM_W'(OFFSET);
  localparam logic [GNUM_W-1:0]  G_HI    = GNUM_W'(OFFSET + NUM_SRC);
  localparam logic [SRVIN_W-1:0] SRV_LIM = SRVIN_W'(NUM_SRV);

  logic [SRV_W-1:0] ent_server [NUM_SRC];
  logic [7:0]       ent_prio   [NUM_SRC];
  logic [NUM_SRC-1:0] want, take;
  logic [IDX_W-1:0] rej_idx, cfg_idx, scan_idx, pick_idx;
  logic rej_ok, cfg_num_ok, cfg_ok, wr_go, scan_done, pick_any, load;

  always_comb begin
    rej_ok     = (rej_num_i >= G_LO) && (rej_num_i < G_HI);
    rej_idx    = IDX_W'(rej_num_i - G_LO);
    cfg_num_ok = (cfg_num_i >= G_LO) && (cfg_num_i < G_HI);
    cfg_idx    = IDX_W'(cfg_num_i - G_LO);
    cfg_ok     = cfg_num_ok &&
                 (!cfg_write_i || ((cfg_server_i < SRV_LIM) && (cfg_prio_i <= 9'h0FF)));
    wr_go      = cfg_valid_i && cfg_write_i && cfg_ok;
    load       = !offer_valid_o || offer_ready_i;
    take       = '0;
    if (load && pick_any) take[pick_idx] = 1'b1;
  end

  isc_scan #(.N(NUM_SRC), .IDX_W(IDX_W)) u_scan (
    .clk(clk), .rst(rst), .start_i(resend_i), .busy_o(busy_o),
    .done_o(scan_done), .idx_o(scan_idx)
  );

  isc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .req_i(want), .any_o(pick_any), .idx_o(pick_idx)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
    isc_entry #(.SRV_W(SRV_W)) u_ent (
      .clk(clk), .rst(rst), .busy_i(busy_o), .flush_i(scan_done),
      .trig_i(trig_i[g]),
      .rej_i(rej_valid_i && rej_ok && (rej_idx == IDX_W'(g))),
      .scan_hit_i(busy_o && (scan_idx == IDX_W'(g))),
      .wr_i(wr_go && (cfg_idx == IDX_W'(g))),
      .wr_server_i(SRV_W'(cfg_server_i)), .wr_prio_i(cfg_prio_i[7:0]),
      .take_i(take[g]), .server_o(ent_server[g]), .prio_o(ent_prio[g]),
      .want_o(want[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offer_valid_o  <= 1'b0;
      offer_num_o    <= '0;
      offer_prio_o   <= '0;
      offer_server_o <= '0;
    end else if (load) begin
      offer_valid_o  <= pick_any;
      offer_num_o    <= G_LO + GNUM_W'(pick_idx);
      offer_prio_o   <= ent_prio[pick_idx];
      offer_server_o <= ent_server[pick_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rsp_valid_o <= 1'b0;
      cfg_status_o    <= ST_OK;
      cfg_server_o    <= '0;
      cfg_prio_o      <= '0;
    end else begin
      cfg_rsp_valid_o <= cfg_valid_i;
      if (cfg_valid_i) begin
        cfg_status_o <= cfg_ok ? ST_OK : ST_ERR;
        if (!cfg_ok) begin
          cfg_server_o <= '0;
          cfg_prio_o   <= '0;
        end else if (cfg_write_i) begin
          cfg_server_o <= SRV_W'(cfg_server_i);
          cfg_prio_o   <= cfg_prio_i[7:0];
        end else begin
          cfg_server_o <= ent_server[cfg_idx];
          cfg_prio_o   <= ent_prio[cfg_idx];
        end
      end
    end
  end

  AST_OFFER_STALL: assert property (@(posedge clk) disable iff (rst)
    (offer_valid_o && !offer_ready_i) |=>
      (offer_valid_o && $stable(offer_num_o) && $stable(offer_prio_o)));  // R8
  AST_OFFER_RANGE: assert property (@(posedge clk) disable iff (rst)
    offer_valid_o |-> (offer_num_o >= G_LO && offer_num_o < G_HI));  // R1
  AST_CFG_REFUSE: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid_i && !cfg_ok) |=> (cfg_rsp_valid_o && cfg_status_o == ST_ERR));  // R9
  AST_CFG_ANSWER: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid_i && cfg_ok && !cfg_write_i) |=> (cfg_status_o == ST_OK));  // R10
endmodule

// File: tb/tb_isc_ctrl.sv
module tb_isc_ctrl;
  localparam int NUM_SRC = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_SRC-1:0] trig_i = '0;
  logic rej_valid_i = 1'b0;
  logic [7:0] rej_num_i = '0;
  logic resend_i = 1'b0;
  logic busy_o, offer_valid_o;
  logic offer_ready_i = 1'b0;
  logic [7:0] offer_num_o, offer_prio_o;
  logic [1:0] offer_server_o;
  logic cfg_valid_i = 1'b0, cfg_write_i = 1'b0;
  logic [7:0] cfg_num_i = '0, cfg_server_i = '0;
  logic [8:0] cfg_prio_i = '0;
  logic cfg_rsp_valid_o;
  logic [7:0] cfg_status_o, cfg_prio_o;
  logic [1:0] cfg_server_o;

  int errors = 0, checks = 0, offers_seen = 0, cyc = 0;
  logic stall = 1'b0;
  logic [17:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  isc_ctrl dut (
    .clk(clk), .rst(rst), .trig_i(trig_i), .rej_valid_i(rej_valid_i),
    .rej_num_i(rej_num_i), .resend_i(resend_i), .busy_o(busy_o),
    .offer_valid_o(offer_valid_o), .offer_ready_i(offer_ready_i),
    .offer_num_o(offer_num_o), .offer_prio_o(offer_prio_o),
    .offer_server_o(offer_server_o), .cfg_valid_i(cfg_valid_i),
    .cfg_write_i(cfg_write_i), .cfg_num_i(cfg_num_i), .cfg_server_i(cfg_server_i),
    .cfg_prio_i(cfg_prio_i), .cfg_rsp_valid_o(cfg_rsp_valid_o),
    .cfg_status_o(cfg_status_o), .cfg_server_o(cfg_server_o), .cfg_prio_o(cfg_prio_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial forever begin
    @(posedge clk); #2;
    cyc++;
    offer_ready_i = stall ? 1'b0 : ((cyc % 3) != 2);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && offer_valid_o && offer_ready_i) begin
      offers_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected offer", int'(offer_num_o), 0);
      end else begin
        logic [17:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({offer_num_o, offer_prio_o, offer_server_o} == e, t,
            int'({offer_num_o, offer_prio_o, offer_server_o}), int'(e));
      end
    end
  end

  task automatic expect_offer(input int num, input int prio, input int srv, input string t);
    exp_q.push_back({8'(num), 8'(prio), 2'(srv)});
    tag_q.push_back(t);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_trig(input logic [NUM_SRC-1:0] m);
    @(posedge clk); #2; trig_i = m;
    @(posedge clk); #2; trig_i = '0;
  endtask

  task automatic pulse_rej(input int num);
    @(posedge clk); #2; rej_valid_i = 1'b1; rej_num_i = 8'(num);
    @(posedge clk); #2; rej_valid_i = 1'b0;
  endtask

  task automatic pulse_resend();
    @(posedge clk); #2; resend_i = 1'b1;
    @(posedge clk); #2; resend_i = 1'b0;
  endtask

  task automatic cfg(input bit wr, input int num, input int srv, input int prio,
                     output int st, output int osrv, output int oprio);
    @(posedge clk); #2;
    cfg_valid_i = 1'b1; cfg_write_i = wr; cfg_num_i = 8'(num);
    cfg_server_i = 8'(srv); cfg_prio_i = 9'(prio);
    @(posedge clk); #2; cfg_valid_i = 1'b0;
    @(negedge clk);
    chk(cfg_rsp_valid_o, "R9 response one cycle later", int'(cfg_rsp_valid_o), 1);
    st = int'(cfg_status_o); osrv = int'(cfg_server_o); oprio = int'(cfg_prio_o);
  endtask

  task automatic drain(input string t);
    int n = 0;
    while (exp_q.size() != 0 && n < 300) begin
      @(negedge clk); n++;
    end
    chk(exp_q.size() == 0, t, exp_q.size(), 0);
    tick(4);
  endtask

  initial begin
    int st, sv, pr, seen, nbusy;
    tick(4);
    rst = 1'b0;
    @(negedge clk);
    chk(!offer_valid_o, "R2 no offer after reset", int'(offer_valid_o), 0);
    chk(!busy_o, "R2 idle after reset", int'(busy_o), 0);
    chk(!cfg_rsp_valid_o, "R2 no response after reset", int'(cfg_rsp_valid_o), 0);
    cfg(1'b0, 16, 0, 0, st, sv, pr);
    chk(st == 0 && pr == 8'hFF && sv == 0, "R2 R10 reset entry masked", pr, 'hFF);

    // masked trigger remembered, replayed on unmask
    seen = offers_seen;
    pulse_trig(16'h0001);
    tick(6);
    chk(offers_seen == seen, "R4 masked trigger gives no offer", offers_seen, seen);
    expect_offer(16, 5, 2, "R4 replay on unmask");
    cfg(1'b1, 16, 2, 5, st, sv, pr);
    chk(st == 0, "R9 accepted write status", st, 0);
    drain("R4 replay drained");
    chk(offers_seen == seen + 1, "R4 single replay", offers_seen, seen + 1);

    // direct offers, ordering
    expect_offer(16, 5, 2, "R3 unmasked trigger");
    pulse_trig(16'h0001);
    drain("R3 drained");
    cfg(1'b1, 19, 1, 'h20, st, sv, pr);
    cfg(1'b1, 31, 3, 'h01, st, sv, pr);
    expect_offer(16, 5, 2, "R8 order first");
    expect_offer(19, 'h20, 1, "R8 order second");
    expect_offer(31, 'h01, 3, "R1 R8 order third, last number");
    pulse_trig(16'h8009);
    drain("R8 ordered drained");

    // stall
    stall = 1'b1;
    expect_offer(19, 'h20, 1, "R8 stalled offer");
    pulse_trig(16'h0008);
    tick(3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(offer_valid_o && offer_num_o == 8'd19, "R8 held while not ready",
          int'(offer_num_o), 19);
    end
    stall = 1'b0;
    drain("R8 stall drained");

    // refused configuration
    cfg(1'b1, 15, 0, 1, st, sv, pr);
    chk(st == 'hFD, "R9 number below range", st, 'hFD);
    cfg(1'b1, 32, 0, 1, st, sv, pr);
    chk(st == 'hFD, "R9 number above range", st, 'hFD);
    cfg(1'b1, 19, 4, 'h40, st, sv, pr);
    chk(st == 'hFD, "R9 server too large", st, 'hFD);
    cfg(1'b1, 19, 0, 'h100, st, sv, pr);
    chk(st == 'hFD, "R9 priority too large", st, 'hFD);
    cfg(1'b0, 40, 0, 0, st, sv, pr);
    chk(st == 'hFD, "R10 read out of range", st, 'hFD);
    cfg(1'b0, 19, 0, 0, st, sv, pr);
    chk(st == 0 && sv == 1 && pr == 'h20, "R9 R10 entry unchanged", pr, 'h20);

    // write that stays masked keeps pending
    seen = offers_seen;
    pulse_trig(16'h0020);
    cfg(1'b1, 21, 1, 'hFF, st, sv, pr);
    tick(6);
    chk(offers_seen == seen, "R4 masked write no offer", offers_seen, seen);
    expect_offer(21, 7, 3, "R4 replay after second write");
    cfg(1'b1, 21, 3, 7, st, sv, pr);
    drain("R4 second drained");

    // rejects and resend
    cfg(1'b1, 24, 0, 'h30, st, sv, pr);
    seen = offers_seen;
    pulse_rej(19);
    pulse_rej(16);
    pulse_rej(200);
    pulse_rej(23);
    tick(6);
    chk(offers_seen == seen, "R5 reject gives no offer", offers_seen, seen);
    expect_offer(16, 5, 2, "R6 resend first");
    expect_offer(19, 'h20, 1, "R6 resend second");
    pulse_resend();
    nbusy = 0;
    while (busy_o && nbusy < 100) begin
      @(negedge clk); if (busy_o) nbusy++;
    end
    chk(nbusy == NUM_SRC, "R6 busy length", nbusy, NUM_SRC);
    drain("R5 R6 resend drained");
    seen = offers_seen;
    pulse_resend();
    tick(NUM_SRC + 8);
    chk(offers_seen == seen, "R6 flags cleared, masked dropped", offers_seen, seen);

    // events during scan
    pulse_resend();
    seen = offers_seen;
    expect_offer(16, 5, 2, "R7 held trigger");
    pulse_trig(16'h0001);
    pulse_rej(31);
    while (busy_o) @(negedge clk);
    chk(offers_seen == seen, "R7 nothing during scan", offers_seen, seen);
    drain("R7 held trigger drained");
    expect_offer(31, 'h01, 3, "R7 held reject");
    pulse_resend();
    tick(NUM_SRC + 4);
    drain("R7 held reject drained");

    finish_run();
  end
endmodule